// File: doc/BRIEF.md
# Reloading Down-Counter Local Timer

A periodic timer that counts down from a programmable reload value. When an active tick would take the count to zero, the timer reloads the count from the reload value. In the same clock cycle it sets a sticky event flag, which stays set until software clears it explicitly. The count is advanced by one of two clock-enable inputs. One is a slow crystal-derived tick, which steps the count by two. The other is a bus-clock tick, which steps the count by one.

Software programs the block through a small write port with three targets:
- a combined control word that holds the reload value and the run and interrupt-enable bits;
- a command word that clears the flag or forces an immediate reload;
- a configuration word that picks the tick source and the core that receives the interrupt.

The interrupt level is the flag ANDed with the interrupt enable. It is steered to exactly one of the core outputs.

Top module: `rtm_local_timer`

## Requirements
- R1: After reset the control word reads 0x00000000, the count is 0, the flag is clear, the source is the bus tick, the route is core 0 and every `irq_core` bit is 0.
- R2: A write to address 0 stores the reload value from bits 27:0, run enable from bit 28 and interrupt enable from bit 29, and loads the count with the new reload value. `ctrl_word` returns these fields at the same positions, returns the flag at bit 31 and returns 0 at bit 30. Bit 31 of the written data is ignored.
- R3: With configuration bit 2 = 0 and run enabled, each `bus_tick` lowers the count by 1, and `xtal_tick` has no effect.
- R4: With configuration bit 2 = 1 and run enabled, each `xtal_tick` lowers the count by 2, and `bus_tick` has no effect.
- R5: An active tick that finds the count at or below the step reloads the count from the reload value. It also sets the flag, visible after that clock edge. A reload value of 0 therefore sets the flag on every active tick.
- R6: The flag stays set until a write to address 1 with bit 31 = 1 clears it. A write to address 1 with bit 31 = 0 leaves the flag unchanged.
- R7: When a clear command and a reload event happen in the same cycle, the flag ends set.
- R8: A write to address 1 with bit 30 = 1 loads the count with the reload value and leaves the flag unchanged. When it coincides with an active tick at the wrap point, the load wins and no flag is set.
- R9: With run enable 0, ticks leave the count unchanged and the flag keeps its value.
- R10: `irq_core[k]` is (flag AND interrupt enable) for k equal to configuration bits 1:0, and 0 for every other k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_tick | input | 1 | Bus-clock tick enable (step 1) |
| xtal_tick | input | 1 | Crystal tick enable (step 2) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 command, 2 configuration, 3 unused |
| wr_data | input | 32 | Write data |
| ctrl_word | output | 32 | Control word with flag at bit 31 |
| count | output | CNT_W | Current count value |
| irq_core | output | N_CORES | Per-core interrupt outputs |

## Verification
The hardest situations to reach are the same-cycle collisions: a clear command, or a forced reload, landing in the very cycle that an active tick takes the count through its wrap point. The bench drives the count to the value just above zero with a known number of ticks. It then uses a task that asserts the write strobe and the tick together in a single cycle, and reads both the flag and the count after that edge. Running this in crystal mode with an odd reload value also covers the step of two jumping past zero.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
   localparam int RTM_CTRL_W = 32;
   localparam int RTM_RELOAD_MAX_W = 28;
   localparam int RTM_BIT_RUN = 28;
   localparam int RTM_BIT_IE = 29;
   localparam int RTM_BIT_RLD = 30;
   localparam int RTM_BIT_FLAG = 31;
   localparam int RTM_BIT_XSRC = 2;

   typedef enum logic [1:0] {
      RTM_A_CTRL = 2'd0,
      RTM_A_CMD  = 2'd1,
      RTM_A_CFG  = 2'd2,
      RTM_A_NONE = 2'd3
   } rtm_addr_e;
endpackage

// File: rtl/rtm_tick_sel.sv
module rtm_tick_sel #(
   parameter int CNT_W = 28,
   parameter int XTAL_STEP = 2
) (
   input  logic             use_xtal,
   input  logic             bus_tick,
   input  logic             xtal_tick,
   output logic             tick,
   output logic [CNT_W-1:0] step
);
   localparam logic [CNT_W-1:0] BUS_INC = CNT_W'(1);
   localparam logic [CNT_W-1:0] XTAL_INC = CNT_W'(XTAL_STEP);

   if (XTAL_STEP < 1 || XTAL_STEP > 15) begin : g_bad_step
      $error("rtm_tick_sel: XTAL_STEP out of range");
   end

   assign tick = use_xtal ? xtal_tick : bus_tick;

   if (XTAL_STEP == 1) begin : g_same_step
      assign step = BUS_INC;
   end else begin : g_dual_step
      assign step = use_xtal ? XTAL_INC : BUS_INC;
   end
endmodule

// File: rtl/rtm_counter.sv
module rtm_counter #(
   parameter int CNT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] step,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic             flag
);
   logic active;
   logic at_wrap;

   assign active  = run && tick;
   assign at_wrap = active && (cnt <= step);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (active) begin
         cnt <= at_wrap ? load_val : cnt - step;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (at_wrap && !load) begin
         flag <= 1'b1;
      end else if (clr) begin
         flag <= 1'b0;
      end
   end

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !load && cnt > step) |=> (cnt == $past(cnt) - $past(step)));

   assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !load && cnt <= step) |=> (flag && cnt == $past(load_val)));

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

   assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !flag && !clr) |=> (!flag && cnt == $past(load_val)));

   assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/rtm_router.sv
module rtm_router #(
   parameter int N_CORES = 4,
   localparam int SEL_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               level,
   input  logic [SEL_W-1:0]   sel,
   output logic [N_CORES-1:0] irq_core
);
   for (genvar k = 0; k < N_CORES; k++) begin : g_core
      assign irq_core[k] = level && (sel == SEL_W'(k));
   end

   assert_one_core_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_core));

   assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !level |-> (irq_core == '0));
endmodule

// File: rtl/rtm_local_timer.sv
module rtm_local_timer #(
   parameter int CNT_W = 28,
   parameter int N_CORES = 4,
   parameter int XTAL_STEP = 2,
   localparam int SEL_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_tick,
   input  logic               xtal_tick,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [31:0]        wr_data,
   output logic [31:0]        ctrl_word,
   output logic [CNT_W-1:0]   count,
   output logic [N_CORES-1:0] irq_core
);
   import rtm_pkg::*;

   if (CNT_W < 2 || CNT_W > RTM_RELOAD_MAX_W) begin : g_bad_width
      $error("rtm_local_timer: CNT_W must be 2..28");
   end
   if (N_CORES < 2 || N_CORES > 4) begin : g_bad_cores
      $error("rtm_local_timer: N_CORES must be 2..4");
   end

   logic [CNT_W-1:0] reload_q;
   logic             run_q;
   logic             ie_q;
   logic [SEL_W-1:0] route_q;
   logic             xsrc_q;

   logic ctrl_wr, cmd_wr, cfg_wr;
   logic load, clr;
   logic [CNT_W-1:0] load_val;
   logic tick;
   logic [CNT_W-1:0] step;
   logic flag;

   assign ctrl_wr = wr_en && (rtm_addr_e'(wr_addr) == RTM_A_CTRL);
   assign cmd_wr  = wr_en && (rtm_addr_e'(wr_addr) == RTM_A_CMD);
   assign cfg_wr  = wr_en && (rtm_addr_e'(wr_addr) == RTM_A_CFG);

   assign load     = ctrl_wr || (cmd_wr && wr_data[RTM_BIT_RLD]);
   assign clr      = cmd_wr && wr_data[RTM_BIT_FLAG];
   assign load_val = ctrl_wr ? wr_data[CNT_W-1:0] : reload_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         run_q    <= 1'b0;
         ie_q     <= 1'b0;
      end else if (ctrl_wr) begin
         reload_q <= wr_data[CNT_W-1:0];
         run_q    <= wr_data[RTM_BIT_RUN];
         ie_q     <= wr_data[RTM_BIT_IE];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route_q <= '0;
         xsrc_q  <= 1'b0;
      end else if (cfg_wr) begin
         route_q <= wr_data[SEL_W-1:0];
         xsrc_q  <= wr_data[RTM_BIT_XSRC];
      end
   end

   rtm_tick_sel #(.CNT_W(CNT_W), .XTAL_STEP(XTAL_STEP)) i_tick_sel (
      .use_xtal (xsrc_q),
      .bus_tick (bus_tick),
      .xtal_tick(xtal_tick),
      .tick     (tick),
      .step     (step)
   );

   rtm_counter #(.CNT_W(CNT_W)) i_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .tick    (tick),
      .step    (step),
      .load    (load),
      .load_val(load_val),
      .clr     (clr),
      .cnt     (count),
      .flag    (flag)
   );

   rtm_router #(.N_CORES(N_CORES)) i_router (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (flag && ie_q),
      .sel     (route_q),
      .irq_core(irq_core)
   );

   always_comb begin
      ctrl_word = '0;
      ctrl_word[CNT_W-1:0]   = reload_q;
      ctrl_word[RTM_BIT_RUN] = run_q;
      ctrl_word[RTM_BIT_IE]  = ie_q;
      ctrl_word[RTM_BIT_FLAG] = flag;
   end

   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   assert_ctrl_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (count == $past(wr_data[CNT_W-1:0]) && !ctrl_word[RTM_BIT_RLD]));

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(run_q && tick && count <= step) ) |=> !ctrl_word[RTM_BIT_FLAG]);

   assert_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !load && run_q && tick && count <= step) |=> ctrl_word[RTM_BIT_FLAG]);
endmodule

// File: tb/test_rtm_local_timer.sv
module test_rtm_local_timer;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 28;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_tick = 1'b0;
   logic xtal_tick = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic [31:0] ctrl_word;
   logic [CNT_W-1:0] count;
   logic [3:0] irq_core;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtm_local_timer #(.CNT_W(CNT_W), .N_CORES(4), .XTAL_STEP(2)) i_rtm_local_timer (
      .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .xtal_tick(xtal_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ctrl_word(ctrl_word), .count(count), .irq_core(irq_core)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // One cycle of stimulus: optional write plus tick inputs, then sample at next negedge
   task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input logic b, input logic x);
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; bus_tick = b; xtal_tick = x;
      @(negedge clk);
      wr_en = 1'b0; bus_tick = 1'b0; xtal_tick = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, 1'b0, 1'b0);
   endtask

   task automatic tk(input logic b, input logic x);
      cyc(1'b0, 2'd0, 32'd0, b, x);
   endtask

   task automatic t_reset;
      chk("R1 ctrl", ctrl_word, 32'h0);
      chk("R1 count", 32'(count), 32'd0);
      chk("R1 irq", 32'(irq_core), 32'd0);
      tk(1'b1, 1'b1);
      chk("R1 idle count", 32'(count), 32'd0);
   endtask

   task automatic t_bus_mode;
      wr(2'd0, 32'h3000_0005);
      chk("R2 readback", ctrl_word, 32'h3000_0005);
      chk("R2 count load", 32'(count), 32'd5);
      for (int i = 0; i < 4; i++) tk(1'b1, 1'b0);
      chk("R3 bus step", 32'(count), 32'd1);
      tk(1'b0, 1'b1);
      chk("R3 xtal ignored", 32'(count), 32'd1);
      chk("R3 no flag yet", 32'(ctrl_word[31]), 32'd0);
      tk(1'b1, 1'b0);
      chk("R5 reload", 32'(count), 32'd5);
      chk("R5 flag", ctrl_word, 32'hB000_0005);
      chk("R10 core0", 32'(irq_core), 32'h1);
   endtask

   task automatic t_route_clear;
      wr(2'd2, 32'h0000_0002);
      chk("R10 core2", 32'(irq_core), 32'h4);
      wr(2'd1, 32'h0000_0000);
      chk("R6 no-op clear", 32'(ctrl_word[31]), 32'd1);
      wr(2'd3, 32'hFFFF_FFFF);
      chk("R6 unused addr", ctrl_word, 32'hB000_0005);
      wr(2'd1, 32'h8000_0000);
      chk("R6 cleared", 32'(ctrl_word[31]), 32'd0);
      chk("R10 irq gone", 32'(irq_core), 32'h0);
   endtask

   task automatic t_xtal_mode;
      wr(2'd2, 32'h0000_0005);
      wr(2'd1, 32'h4000_0000);
      chk("R8 reload cmd", 32'(count), 32'd5);
      tk(1'b0, 1'b1);
      chk("R4 xtal step", 32'(count), 32'd3);
      tk(1'b1, 1'b0);
      chk("R4 bus ignored", 32'(count), 32'd3);
      tk(1'b0, 1'b1);
      chk("R4 xtal step2", 32'(count), 32'd1);
      tk(1'b0, 1'b1);
      chk("R5 odd wrap", 32'(count), 32'd5);
      chk("R5 xtal flag", 32'(ctrl_word[31]), 32'd1);
      chk("R10 core1", 32'(irq_core), 32'h2);
   endtask

   task automatic t_disable;
      wr(2'd0, 32'h2000_0007);
      chk("R9 load while stopped", 32'(count), 32'd7);
      tk(1'b0, 1'b1);
      tk(1'b0, 1'b1);
      chk("R9 frozen", 32'(count), 32'd7);
      chk("R9 flag kept", 32'(ctrl_word[31]), 32'd1);
      wr(2'd0, 32'h1000_0007);
      chk("R10 ie off", 32'(irq_core), 32'h0);
      chk("R2 flag bit31", ctrl_word, 32'h9000_0007);
   endtask

   task automatic t_collide;
      wr(2'd1, 32'h8000_0000);
      for (int i = 0; i < 3; i++) tk(1'b0, 1'b1);
      chk("R7 setup", 32'(count), 32'd1);
      cyc(1'b1, 2'd1, 32'h8000_0000, 1'b0, 1'b1);
      chk("R7 set wins", 32'(ctrl_word[31]), 32'd1);
      chk("R7 count", 32'(count), 32'd7);
      wr(2'd1, 32'h8000_0000);
      for (int i = 0; i < 3; i++) tk(1'b0, 1'b1);
      cyc(1'b1, 2'd1, 32'h4000_0000, 1'b0, 1'b1);
      chk("R8 load wins flag", 32'(ctrl_word[31]), 32'd0);
      chk("R8 load wins count", 32'(count), 32'd7);
   endtask

   task automatic t_zero_reload;
      wr(2'd0, 32'h9000_0000);
      chk("R2 bit31 ignored", ctrl_word, 32'h1000_0000);
      tk(1'b0, 1'b1);
      chk("R5 zero reload flag", 32'(ctrl_word[31]), 32'd1);
      chk("R5 zero reload count", 32'(count), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bus_mode();
      t_route_clear();
      t_xtal_mode();
      t_disable();
      t_collide();
      t_zero_reload();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule